// File: doc/BRIEF.md
# Mod-7 Divisibility Checker

This block decides, in pure combinational logic, whether an unsigned N-bit value is an exact multiple of seven, and also reports the remainder. Eight leaves a remainder of one when divided by seven. So a 3-bit slice of the input placed at any multiple of three bit positions adds to the remainder exactly as if it sat at the bottom. The input is therefore cut into 3-bit digits, and the most significant digit is zero-filled when N is not a multiple of three.

The digits are reduced by layers of 3:2 compressors. Each compressor adds three digits bit by bit with full adders. It forms a sum word and a carry word, and the carry that would land on weight eight is sent round to weight one. Every operand therefore stays three bits wide, and the remainder modulo seven does not change. Each layer shrinks the operand count by about a third, so the depth grows with the logarithm of N. Two digits remain at the end. A short test on this pair gives the verdict, and a small add-and-fold gives the remainder.

Top module: `mod7_div_check`

## Requirements
- R1: `divisible` is 1 exactly when `value` mod 7 equals 0, for every input value.
- R2: `residue` equals `value` mod 7, as an unsigned number in the range 0 to 6; the code 7 never appears.
- R3: When N is not a multiple of three, the missing upper bits of the top digit count as zero, so R1 and R2 still hold (checked with N = 8 and N = 128).
- R4: Each 3:2 compressor outputs two digits whose sum is congruent modulo 7 to the sum of its three input digits.
- R5: The final pair (x, y) is judged divisible when x XOR y = 3'b111, and also when both are 3'b000 or both are 3'b111. Any other equal pair is judged not divisible.
- R6: An all-zero `value` gives `divisible` = 1 and `residue` = 0, and an all-ones value gives the arithmetic remainder of 2^N - 1.
- R7: A width of N of three or less, which gives a single digit, is handled correctly.
- R8: The outputs depend only on the present `value`, with no clock and no stored state, so they settle within the same time step as an input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| value | input | N | Unsigned number under test |
| divisible | output | 1 | 1 when value is a multiple of seven |
| residue | output | 3 | value mod 7, range 0..6 |

## Verification
The hard case is the last pair whose sum is fourteen, with both digits 3'b111. Here the two digits are equal, yet the input is divisible, unlike every other equal pair. Which pair reaches the final test depends on how the whole tree reduces the input, so this case cannot be aimed at from the ports. Exhaustive sweeps of the 12-bit, 8-bit and 2-bit builds therefore drive every input. In doing so they pass every reachable final pair, the fourteen case among them, through the verdict logic. Each result is compared with the bench's own `%` arithmetic. Corner and random vectors on the 128-bit build then cover the deep tree and the padded top digit.

// File: rtl/mod7_pkg.sv
package mod7_pkg;

    localparam int DIGIT_W = 3;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t sum;
        digit_t wrap;
    } csa_pair_t;

    function automatic int digits_for(input int width);
        int g;
        g = (width + DIGIT_W - 1) / DIGIT_W;
        return (g < 2) ? 2 : g;
    endfunction

    function automatic int next_count(input int c);
        return 2 * (c / 3) + (c % 3);
    endfunction

    function automatic int ops_at(input int g, input int layer);
        int c;
        c = g;
        for (int i = 0; i < layer; i++) c = next_count(c);
        return c;
    endfunction

    function automatic int layer_count(input int g);
        int c;
        int n;
        c = g;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            if (c > 2) begin
                c = next_count(c);
                n++;
            end
        end
        return n;
    endfunction

    function automatic int offset_at(input int g, input int layer);
        int s;
        s = 0;
        for (int i = 0; i < layer; i++) s += ops_at(g, i);
        return s;
    endfunction

endpackage

// File: rtl/mod7_csa.sv
module mod7_csa
    import mod7_pkg::*;
(
    input  digit_t    a,
    input  digit_t    b,
    input  digit_t    c,
    output csa_pair_t q
);
    digit_t cy;

    always_comb begin
        q.sum = a ^ b ^ c;
        for (int i = 0; i < DIGIT_W; i++)
            cy[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
        q.wrap = {cy[1], cy[0], cy[2]};
    end

    always_comb begin
        if (!$isunknown({a, b, c}))
            assert_csa_keeps_residue_R4: assert (
                ((5'(a) + 5'(b) + 5'(c)) % 5'd7) == ((5'(q.sum) + 5'(q.wrap)) % 5'd7))
            else $error("compressor changed residue");
    end
endmodule

// File: rtl/mod7_layer.sv
module mod7_layer
    import mod7_pkg::*;
#(
    parameter int CNT_IN = 3
)(
    input  logic [CNT_IN-1:0][DIGIT_W-1:0]                     ops_in,
    output logic [2*(CNT_IN/3)+(CNT_IN%3)-1:0][DIGIT_W-1:0]    ops_out
);
    localparam int NCSA = CNT_IN / 3;
    localparam int REM  = CNT_IN % 3;

    genvar i;
    generate
        for (i = 0; i < NCSA; i++) begin : g_csa
            csa_pair_t pr;
            mod7_csa i_csa (
                .a (ops_in[3*i]),
                .b (ops_in[3*i+1]),
                .c (ops_in[3*i+2]),
                .q (pr)
            );
            assign ops_out[2*i]   = pr.sum;
            assign ops_out[2*i+1] = pr.wrap;
        end
        for (i = 0; i < REM; i++) begin : g_pass
            assign ops_out[2*NCSA+i] = ops_in[3*NCSA+i];
        end
    endgenerate
endmodule

// File: rtl/mod7_final.sv
module mod7_final
    import mod7_pkg::*;
(
    input  digit_t x,
    input  digit_t y,
    output logic   divisible,
    output digit_t residue
);
    logic [3:0] s4;
    digit_t     folded;

    always_comb begin
        divisible = ((x ^ y) == 3'b111) ||
                    ((x == y) && ((x == 3'b000) || (x == 3'b111)));
        s4        = {1'b0, x} + {1'b0, y};
        folded    = s4[2:0] + {2'b00, s4[3]};
        residue   = (folded == 3'd7) ? 3'd0 : folded;
    end

    always_comb begin
        if (!$isunknown({x, y})) begin
            assert_verdict_matches_pair_R5: assert (
                divisible == (((4'(x) + 4'(y)) % 4'd7) == 4'd0))
            else $error("pair verdict wrong");
            assert_residue_range_R2: assert (residue != 3'd7)
            else $error("residue code 7");
        end
    end
endmodule

// File: rtl/mod7_div_check.sv
module mod7_div_check
    import mod7_pkg::*;
#(
    parameter int N = 128
)(
    input  logic [N-1:0] value,
    output logic         divisible,
    output logic [2:0]   residue
);
    localparam int G0     = digits_for(N);
    localparam int LAYERS = layer_count(G0);
    localparam int TOTAL  = offset_at(G0, LAYERS) + 2;
    localparam int PW     = DIGIT_W * G0;
    localparam int FIN    = offset_at(G0, LAYERS);

    logic [DIGIT_W*TOTAL-1:0] bus;

    assign bus[PW-1:0] = PW'(value);

    genvar l;
    generate
        for (l = 0; l < LAYERS; l++) begin : g_layer
            localparam int CI = ops_at(G0, l);
            localparam int CO = ops_at(G0, l + 1);
            localparam int OI = offset_at(G0, l);
            localparam int OO = offset_at(G0, l + 1);
            mod7_layer #(.CNT_IN(CI)) i_layer (
                .ops_in  (bus[DIGIT_W*(OI+CI)-1 : DIGIT_W*OI]),
                .ops_out (bus[DIGIT_W*(OO+CO)-1 : DIGIT_W*OO])
            );
        end
    endgenerate

    mod7_final i_final (
        .x         (bus[DIGIT_W*FIN+2 : DIGIT_W*FIN]),
        .y         (bus[DIGIT_W*FIN+5 : DIGIT_W*FIN+3]),
        .divisible (divisible),
        .residue   (residue)
    );

    always_comb begin
        if (!$isunknown(value)) begin
            assert_verdict_R1: assert (divisible == ((value % 7) == 0))
            else $error("divisible flag wrong");
            assert_zero_input_R6: assert ((value != '0) || (divisible && residue == 3'd0))
            else $error("zero input not divisible");
        end
    end
endmodule

// File: tb/test_mod7_div_check.sv
module test_mod7_div_check;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [11:0]  v12;  logic d12;  logic [2:0] r12;
    logic [7:0]   v8;   logic d8;   logic [2:0] r8;
    logic [1:0]   v2;   logic d2;   logic [2:0] r2;
    logic [127:0] v128; logic d128; logic [2:0] r128;

    mod7_div_check #(.N(12))  i_mod7_div_check      (.value(v12),  .divisible(d12),  .residue(r12));
    mod7_div_check #(.N(8))   i_mod7_div_check_n8   (.value(v8),   .divisible(d8),   .residue(r8));
    mod7_div_check #(.N(2))   i_mod7_div_check_n2   (.value(v2),   .divisible(d2),   .residue(r2));
    mod7_div_check #(.N(128)) i_mod7_div_check_n128 (.value(v128), .divisible(d128), .residue(r128));

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic run128(input logic [127:0] v, input string tag);
        int e;
        @(negedge clk);
        v128 = v;
        #1;
        e = int'(v % 128'd7);
        chk({tag, " divisible"}, int'(d128), int'(e == 0));
        chk({tag, " residue"},   int'(r128), e);
    endtask

    initial begin
        v12 = '0; v8 = '0; v2 = '0; v128 = '0;
        @(negedge clk); #1;
        // R6: zero input
        chk("R6 zero divisible", int'(d12), 1);
        chk("R6 zero residue",   int'(r12), 0);

        // R1, R2, R5: exhaustive 12-bit sweep (all final pairs reached)
        for (int v = 0; v < 4096; v++) begin
            @(negedge clk);
            v12 = 12'(v);
            #1;
            chk("R1 n12 divisible", int'(d12), int'((v % 7) == 0));
            chk("R2 n12 residue",   int'(r12), v % 7);
        end

        // R3: 8-bit build, top digit padded
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            v8 = 8'(v);
            #1;
            chk("R3 n8 divisible", int'(d8), int'((v % 7) == 0));
            chk("R3 n8 residue",   int'(r8), v % 7);
        end

        // R7: single digit build
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            v2 = 2'(v);
            #1;
            chk("R7 n2 divisible", int'(d2), int'((v % 7) == 0));
            chk("R7 n2 residue",   int'(r2), v % 7);
        end

        // R8: output follows input in the same time step, no clock edge
        @(negedge clk);
        v12 = 12'd49;
        #0.5;
        chk("R8 same-step divisible", int'(d12), 1);
        v12 = 12'd50;
        #0.5;
        chk("R8 same-step residue", int'(r12), 1);

        // R6, R3: 128-bit corners (2^128-1 mod 7 = 3)
        run128('0, "R6 n128 zero");
        run128('1, "R6 n128 ones");
        run128(128'd7, "R1 n128 seven");
        run128({1'b1, 127'd0}, "R3 n128 top bit");
        run128(128'd14, "R5 n128 fourteen");
        for (int k = 0; k < 400; k++)
            run128({$urandom, $urandom, $urandom, $urandom}, "R1 n128 random");
        for (int k = 0; k < 200; k++) begin
            logic [127:0] base;
            base = {$urandom, $urandom, $urandom, 32'd0} / 7;
            run128(base * 7, "R1 n128 multiple");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule